// File: doc/BRIEF.md
# Stereo and Interlaced Raster Timing Generator

This block turns a pixel clock into a video raster. It drives horizontal sync, vertical sync, data-enable, a field-parity flag and an eye flag. The horizontal line shape is programmed once. The vertical shape is programmed four times, once for each field slot: left odd, left even, right odd and right even. Each slot has its own sync length, back porch, active lines, front porch and half-line shift bit. Two mode bits decide which slots make up a frame. With both bits clear the output is plain progressive video. The interlace bit adds the even fields. The stereo bit adds the right-eye fields. With both bits set, all four slots run.

Software holds the soft reset while it rewrites the timing inputs, then releases it. The raster then starts on the first pixel of the left-odd field. The configuration is copied into shadow registers only while the block is held or at the end of a whole frame. Changes made during a running frame therefore take effect at the next frame start. In interlaced modes the programmed active height is the height of one field, which is half the picture.

Top module: `field_timing_gen`

## Requirements
- R1: While the synchronous reset `rst` is high, all five outputs are low on the next clock edge and stay low.
- R2: While `soft_rst` is high or `enable` is low, the counters are held and all outputs are low. On the first clock edge with `enable` high and `soft_rst` low, the outputs show pixel 0 of line 0 of the left-odd field. Output registers add one cycle of latency.
- R3: A line lasts `h_sync_w + h_back + h_active + h_front` pixels. `hsync` is high for the first `h_sync_w` pixels of each line. `h_sync_w` must be at least 1.
- R4: A field of slot s (0 = left odd, 1 = left even, 2 = right odd, 3 = right even) lasts `v_sync_w[s] + v_back[s] + v_active[s] + v_front[s]` lines. Without a half-line shift, `vsync` is high for its first `v_sync_w[s]` whole lines. `v_sync_w[s]` must be at least 1.
- R5: When `v_half_shift[s]` is set, `vsync` goes high at pixel floor(L/2) of line 0 and goes low at pixel floor(L/2) of line `v_sync_w[s]`, where L is the line length.
- R6: `de` is high only on pixels whose index lies in [sync+back, sync+back+active) in both the horizontal and the vertical direction of the current field.
- R7: The fields run in slot order 0, 1, 2, 3, skipping slots that are not enabled. Slot 1 needs `interlace_en`, slot 2 needs `stereo_en`, and slot 3 needs both. After the last enabled slot the sequence returns to slot 0.
- R8: `field_even` is bit 0 of the current slot number and `eye_right` is bit 1. Both change only on the first pixel of a field.
- R9: Changes to any timing or mode input while the raster runs have no effect until the first pixel of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Output enable; low holds the raster |
| soft_rst | input | 1 | Soft reset; high holds the raster while it is reprogrammed |
| interlace_en | input | 1 | Adds the even fields |
| stereo_en | input | 1 | Adds the right-eye fields |
| h_sync_w | input | HW | Horizontal sync length in pixels |
| h_back | input | HW | Horizontal back porch |
| h_active | input | HW | Active pixels per line |
| h_front | input | HW | Horizontal front porch |
| v_sync_w | input | 4 x VW | Vertical sync lines, one per slot |
| v_back | input | 4 x VW | Vertical back porch, one per slot |
| v_active | input | 4 x VW | Active lines per field, one per slot |
| v_front | input | 4 x VW | Vertical front porch, one per slot |
| v_half_shift | input | 4 | Half-line vsync shift bit, one per slot |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| field_even | output | 1 | High during even fields |
| eye_right | output | 1 | High during right-eye fields |

## Verification
The bench targets four kinds of fault. The first is a wrong slot order: skipping or repeating a field shifts every later line and shows up on `field_even` or `eye_right` within one frame. The second is a half-line shift at the wrong place: an off-by-one at the midpoint, or a shifted pulse that is one line too long, moves a `vsync` edge by a pixel or a line. The third is zero-length porches, which expose window compares that use the wrong bound. The last is a mid-frame reprogram: a design whose shadow copy reloads too early changes `de` inside the running frame.

// File: rtl/field_timing_pkg.sv
`timescale 1ns/1ps
package field_timing_pkg;
  typedef enum logic [1:0] {
    SLOT_LO = 2'd0,
    SLOT_LE = 2'd1,
    SLOT_RO = 2'd2,
    SLOT_RE = 2'd3
  } slot_e;

  // Next field slot for the given mode bits; order is LO, LE, RO, RE.
  function automatic slot_e next_slot(slot_e cur, logic il, logic st);
    slot_e n;
    case (cur)
      SLOT_LO: n = il ? SLOT_LE : (st ? SLOT_RO : SLOT_LO);
      SLOT_LE: n = st ? SLOT_RO : SLOT_LO;
      SLOT_RO: n = il ? SLOT_RE : SLOT_LO;
      default: n = SLOT_LO;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tg_shadow.sv
`timescale 1ns/1ps
module tg_shadow #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int NSLOT = 4
) (
  input  logic                        clk,
  input  logic                        load,
  input  logic                        il_i,
  input  logic                        st_i,
  input  logic [HW-1:0]               hs_i,
  input  logic [HW-1:0]               hbp_i,
  input  logic [HW-1:0]               ha_i,
  input  logic [HW-1:0]               hfp_i,
  input  logic [NSLOT-1:0][VW-1:0]    vs_i,
  input  logic [NSLOT-1:0][VW-1:0]    vbp_i,
  input  logic [NSLOT-1:0][VW-1:0]    va_i,
  input  logic [NSLOT-1:0][VW-1:0]    vfp_i,
  input  logic [NSLOT-1:0]            shm_i,
  output logic                        il_o,
  output logic                        st_o,
  output logic [HW-1:0]               hs_o,
  output logic [HW-1:0]               hbp_o,
  output logic [HW-1:0]               ha_o,
  output logic [HW-1:0]               hfp_o,
  output logic [NSLOT-1:0][VW-1:0]    vs_o,
  output logic [NSLOT-1:0][VW-1:0]    vbp_o,
  output logic [NSLOT-1:0][VW-1:0]    va_o,
  output logic [NSLOT-1:0][VW-1:0]    vfp_o,
  output logic [NSLOT-1:0]            shm_o
);
  // Shared horizontal shape and mode bits
  always_ff @(posedge clk) begin
    if (load) begin
      il_o  <= il_i;
      st_o  <= st_i;
      hs_o  <= hs_i;
      hbp_o <= hbp_i;
      ha_o  <= ha_i;
      hfp_o <= hfp_i;
    end
  end

  // One vertical set per field slot
  for (genvar s = 0; s < NSLOT; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (load) begin
        vs_o[s]  <= vs_i[s];
        vbp_o[s] <= vbp_i[s];
        va_o[s]  <= va_i[s];
        vfp_o[s] <= vfp_i[s];
        shm_o[s] <= shm_i[s];
      end
    end
  end
endmodule

// File: rtl/tg_hcount.sv
`timescale 1ns/1ps
module tg_hcount #(
  parameter int HW = 12,
  localparam int HT = HW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] hs,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] ha,
  input  logic [HW-1:0] hfp,
  output logic          line_end,
  output logic          h_sync,
  output logic          h_act,
  output logic          before_half
);
  logic [HT-1:0] hcnt;
  logic [HT-1:0] htot;
  logic [HT-1:0] act_lo;
  logic [HT-1:0] act_hi;

  always_comb begin
    act_lo      = HT'(hs) + HT'(hbp);
    act_hi      = act_lo + HT'(ha);
    htot        = act_hi + HT'(hfp);
    line_end    = (hcnt == htot - HT'(1));
    h_sync      = (hcnt < HT'(hs));
    h_act       = (hcnt >= act_lo) && (hcnt < act_hi);
    before_half = (hcnt < (htot >> 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run)   hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + HT'(1);
  end
endmodule

// File: rtl/tg_vseq.sv
`timescale 1ns/1ps
module tg_vseq
  import field_timing_pkg::*;
#(
  parameter int VW = 12,
  parameter int NSLOT = 4,
  localparam int VT = VW + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     line_end,
  input  logic                     il,
  input  logic                     st,
  input  logic [NSLOT-1:0][VW-1:0] vs,
  input  logic [NSLOT-1:0][VW-1:0] vbp,
  input  logic [NSLOT-1:0][VW-1:0] va,
  input  logic [NSLOT-1:0][VW-1:0] vfp,
  input  logic [NSLOT-1:0]         shm,
  output slot_e                    slot,
  output logic                     frame_end,
  output logic                     v_first,
  output logic                     v_in_sync,
  output logic                     v_sync_last,
  output logic                     v_act,
  output logic                     v_shift
);
  logic [VT-1:0] vcnt;
  logic [NSLOT-1:0][VT-1:0] act_lo_a, act_hi_a, vtot_a;
  logic [VT-1:0] sel_lo, sel_hi, sel_tot, sel_vs;
  logic field_end;

  // Per-slot line totals, computed in parallel
  for (genvar s = 0; s < NSLOT; s++) begin : g_tot
    always_comb begin
      act_lo_a[s] = VT'(vs[s]) + VT'(vbp[s]);
      act_hi_a[s] = act_lo_a[s] + VT'(va[s]);
      vtot_a[s]   = act_hi_a[s] + VT'(vfp[s]);
    end
  end

  always_comb begin
    sel_lo      = act_lo_a[slot];
    sel_hi      = act_hi_a[slot];
    sel_tot     = vtot_a[slot];
    sel_vs      = VT'(vs[slot]);
    v_shift     = shm[slot];
    v_first     = (vcnt == '0);
    v_in_sync   = (vcnt < sel_vs);
    v_sync_last = (vcnt == sel_vs);
    v_act       = (vcnt >= sel_lo) && (vcnt < sel_hi);
    field_end   = line_end && (vcnt == sel_tot - VT'(1));
    frame_end   = field_end && (next_slot(slot, il, st) == SLOT_LO);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      vcnt <= '0;
      slot <= SLOT_LO;
    end else if (field_end) begin
      vcnt <= '0;
      slot <= next_slot(slot, il, st);
    end else if (line_end) begin
      vcnt <= vcnt + VT'(1);
    end
  end
endmodule

// File: rtl/field_timing_gen.sv
`timescale 1ns/1ps
module field_timing_gen
  import field_timing_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_rst,
  input  logic              interlace_en,
  input  logic              stereo_en,
  input  logic [HW-1:0]     h_sync_w,
  input  logic [HW-1:0]     h_back,
  input  logic [HW-1:0]     h_active,
  input  logic [HW-1:0]     h_front,
  input  logic [3:0][VW-1:0] v_sync_w,
  input  logic [3:0][VW-1:0] v_back,
  input  logic [3:0][VW-1:0] v_active,
  input  logic [3:0][VW-1:0] v_front,
  input  logic [3:0]        v_half_shift,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              field_even,
  output logic              eye_right
);
  localparam int NSLOT = 4;

  logic run, load, frame_end;
  logic il_q, st_q;
  logic [HW-1:0] hs_q, hbp_q, ha_q, hfp_q;
  logic [NSLOT-1:0][VW-1:0] vs_q, vbp_q, va_q, vfp_q;
  logic [NSLOT-1:0] shm_q;
  logic line_end, h_sync, h_act, before_half;
  logic v_first, v_in_sync, v_sync_last, v_act, v_shift;
  slot_e slot;
  logic vsync_n;

  assign run  = enable && !soft_rst;
  // Shadow copy follows the inputs while held, and otherwise only at a frame boundary
  assign load = !run || frame_end;

  tg_shadow #(.HW(HW), .VW(VW), .NSLOT(NSLOT)) u_shadow (
    .clk(clk), .load(load),
    .il_i(interlace_en), .st_i(stereo_en),
    .hs_i(h_sync_w), .hbp_i(h_back), .ha_i(h_active), .hfp_i(h_front),
    .vs_i(v_sync_w), .vbp_i(v_back), .va_i(v_active), .vfp_i(v_front),
    .shm_i(v_half_shift),
    .il_o(il_q), .st_o(st_q),
    .hs_o(hs_q), .hbp_o(hbp_q), .ha_o(ha_q), .hfp_o(hfp_q),
    .vs_o(vs_q), .vbp_o(vbp_q), .va_o(va_q), .vfp_o(vfp_q),
    .shm_o(shm_q)
  );

  tg_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .run(run),
    .hs(hs_q), .hbp(hbp_q), .ha(ha_q), .hfp(hfp_q),
    .line_end(line_end), .h_sync(h_sync), .h_act(h_act),
    .before_half(before_half)
  );

  tg_vseq #(.VW(VW), .NSLOT(NSLOT)) u_v (
    .clk(clk), .rst(rst), .run(run), .line_end(line_end),
    .il(il_q), .st(st_q),
    .vs(vs_q), .vbp(vbp_q), .va(va_q), .vfp(vfp_q), .shm(shm_q),
    .slot(slot), .frame_end(frame_end),
    .v_first(v_first), .v_in_sync(v_in_sync), .v_sync_last(v_sync_last),
    .v_act(v_act), .v_shift(v_shift)
  );

  // Shifted pulse spans from mid-line 0 to mid-line of the first line after sync
  always_comb begin
    if (v_shift)
      vsync_n = (v_first && !before_half) ||
                (!v_first && v_in_sync) ||
                (v_sync_last && before_half);
    else
      vsync_n = v_in_sync;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hsync      <= 1'b0;
      vsync      <= 1'b0;
      de         <= 1'b0;
      field_even <= 1'b0;
      eye_right  <= 1'b0;
    end else begin
      hsync      <= h_sync;
      vsync      <= vsync_n;
      de         <= h_act && v_act;
      field_even <= slot[0];
      eye_right  <= slot[1];
    end
  end
endmodule

// File: rtl/field_timing_gen_chk.sv
`timescale 1ns/1ps
module field_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic soft_rst,
  input logic hsync,
  input logic vsync,
  input logic de,
  input logic field_even,
  input logic eye_right
);
  logic run;
  assign run = enable && !soft_rst;

  // R1: reset clears every output
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!hsync && !vsync && !de && !field_even && !eye_right));

  // R2: hold keeps every output low
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (!hsync && !vsync && !de && !field_even && !eye_right));

  // R6: data enable never overlaps horizontal sync
  a_r6_de_outside_sync: assert property (@(posedge clk) disable iff (rst)
    de |-> !hsync);

  // R8: field flags change only on the first pixel of a field
  a_r8_flags_at_field_start: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && $past(run, 2) && !$past(rst) && !$past(rst, 2) &&
     (($past(eye_right) != eye_right) || ($past(field_even) != field_even)))
    |-> hsync);
endmodule

bind field_timing_gen field_timing_gen_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
  .hsync(hsync), .vsync(vsync), .de(de),
  .field_even(field_even), .eye_right(eye_right)
);

// File: tb/tb_field_timing_gen.sv
`timescale 1ns/1ps
module tb_field_timing_gen;
  localparam int HW = 12;
  localparam int VW = 12;

  typedef struct packed {
    logic [7:0] hs, hbp, ha, hfp, vs, vbp, va, vfp;
    logic il, st;
    logic [3:0] shm;
  } cfg_t;

  localparam int NCFG = 5;
  localparam cfg_t TABLE [NCFG] = '{
    '{8'd2, 8'd2, 8'd6, 8'd2, 8'd2, 8'd1, 8'd4, 8'd1, 1'b0, 1'b0, 4'b0000},
    '{8'd3, 8'd1, 8'd5, 8'd2, 8'd1, 8'd2, 8'd3, 8'd2, 1'b1, 1'b0, 4'b0010},
    '{8'd1, 8'd2, 8'd4, 8'd1, 8'd2, 8'd1, 8'd3, 8'd1, 1'b0, 1'b1, 4'b0000},
    '{8'd2, 8'd1, 8'd6, 8'd3, 8'd2, 8'd2, 8'd3, 8'd1, 1'b1, 1'b1, 4'b1010},
    '{8'd1, 8'd0, 8'd5, 8'd0, 8'd1, 8'd0, 8'd2, 8'd0, 1'b1, 1'b1, 4'b1010}
  };

  logic clk = 1'b0;
  logic rst, enable, soft_rst, interlace_en, stereo_en;
  logic [HW-1:0] h_sync_w, h_back, h_active, h_front;
  logic [3:0][VW-1:0] v_sync_w, v_back, v_active, v_front;
  logic [3:0] v_half_shift;
  logic hsync, vsync, de, field_even, eye_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  field_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
    .interlace_en(interlace_en), .stereo_en(stereo_en),
    .h_sync_w(h_sync_w), .h_back(h_back), .h_active(h_active), .h_front(h_front),
    .v_sync_w(v_sync_w), .v_back(v_back), .v_active(v_active), .v_front(v_front),
    .v_half_shift(v_half_shift),
    .hsync(hsync), .vsync(vsync), .de(de), .field_even(field_even), .eye_right(eye_right)
  );

  function automatic logic [4:0] obs();
    return {hsync, vsync, de, field_even, eye_right};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit slot_on(cfg_t c, int s);
    return (s == 0) || (s == 1 && c.il) || (s == 2 && c.st) || (s == 3 && c.il && c.st);
  endfunction

  // Slot s uses front porch vfp + s so the four sets differ
  function automatic int field_lines(cfg_t c, int s);
    return int'(c.vs) + int'(c.vbp) + int'(c.va) + int'(c.vfp) + s;
  endfunction

  function automatic int line_len(cfg_t c);
    return int'(c.hs) + int'(c.hbp) + int'(c.ha) + int'(c.hfp);
  endfunction

  function automatic int frame_len(cfg_t c);
    int f = 0;
    for (int s = 0; s < 4; s++)
      if (slot_on(c, s)) f += field_lines(c, s) * line_len(c);
    return f;
  endfunction

  // Expected {hsync, vsync, de, field_even, eye_right} at output index k
  function automatic logic [4:0] model(cfg_t c, int k);
    int h = line_len(c);
    int r = k % frame_len(c);
    int slot = 0;
    int line, pix, hlo, vlo, vsl;
    bit hs_e, vs_e, de_e;
    for (int s = 0; s < 4; s++) begin
      if (slot_on(c, s)) begin
        if (r < field_lines(c, s) * h) begin
          slot = s;
          break;
        end
        r -= field_lines(c, s) * h;
      end
    end
    line = r / h;
    pix  = r % h;
    hlo  = int'(c.hs) + int'(c.hbp);
    vlo  = int'(c.vs) + int'(c.vbp);
    vsl  = int'(c.vs) * h;
    hs_e = pix < int'(c.hs);
    if (c.shm[slot]) vs_e = (r >= h / 2) && (r < vsl + h / 2);
    else             vs_e = r < vsl;
    de_e = (pix >= hlo) && (pix < hlo + int'(c.ha)) &&
           (line >= vlo) && (line < vlo + int'(c.va));
    return {hs_e, vs_e, de_e, slot[0], slot[1]};
  endfunction

  task automatic apply(cfg_t c);
    interlace_en = c.il;
    stereo_en    = c.st;
    h_sync_w = HW'(c.hs);
    h_back   = HW'(c.hbp);
    h_active = HW'(c.ha);
    h_front  = HW'(c.hfp);
    for (int s = 0; s < 4; s++) begin
      v_sync_w[s] = VW'(c.vs);
      v_back[s]   = VW'(c.vbp);
      v_active[s] = VW'(c.va);
      v_front[s]  = VW'(int'(c.vfp) + s);
    end
    v_half_shift = c.shm;
  endtask

  // Hold, program, release; the next posedge is output index 0
  task automatic restart(cfg_t c);
    @(negedge clk);
    soft_rst = 1'b1;
    apply(c);
    @(negedge clk);
    @(negedge clk);
    chk(obs() == 5'd0, "R2 outputs low while held", int'(obs()), 0);
    soft_rst = 1'b0;
  endtask

  initial begin : main
    int mism [5];
    int m;
    int f;
    cfg_t a, b;
    rst = 1'b1; enable = 1'b1; soft_rst = 1'b0;
    apply(TABLE[0]);
    repeat (3) @(negedge clk);
    chk(obs() == 5'd0, "R1 outputs low in reset", int'(obs()), 0);
    @(negedge clk);
    soft_rst = 1'b1;
    rst = 1'b0;

    // Table walk: two whole frames per configuration
    for (int e = 0; e < NCFG; e++) begin
      restart(TABLE[e]);
      for (int i = 0; i < 5; i++) mism[i] = 0;
      f = frame_len(TABLE[e]);
      for (int k = 0; k < 2 * f; k++) begin
        @(negedge clk);
        for (int i = 0; i < 5; i++)
          if (obs()[4-i] !== model(TABLE[e], k)[4-i]) mism[i]++;
      end
      chk(mism[0] == 0, $sformatf("R3 hsync cfg%0d mismatches", e), mism[0], 0);
      chk(mism[1] == 0, $sformatf("R4/R5 vsync cfg%0d mismatches", e), mism[1], 0);
      chk(mism[2] == 0, $sformatf("R6 de cfg%0d mismatches", e), mism[2], 0);
      chk(mism[3] == 0, $sformatf("R7 field_even cfg%0d mismatches", e), mism[3], 0);
      chk(mism[4] == 0, $sformatf("R8 eye_right cfg%0d mismatches", e), mism[4], 0);
    end

    // R2: dropping enable mid-frame clears outputs, re-enable restarts at left-odd pixel 0
    restart(TABLE[3]);
    repeat (37) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(obs() == 5'd0, "R2 outputs low after enable drop", int'(obs()), 0);
    repeat (4) @(negedge clk);
    chk(obs() == 5'd0, "R2 outputs stay low while disabled", int'(obs()), 0);
    enable = 1'b1;
    m = 0;
    for (int k = 0; k < frame_len(TABLE[3]); k++) begin
      @(negedge clk);
      if (obs() !== model(TABLE[3], k)) m++;
    end
    chk(m == 0, "R2 restart from frame start after re-enable", m, 0);

    // R9: a mid-frame change waits for the next frame start
    a = TABLE[0];
    b = a;
    b.ha  = 8'd4;
    b.hfp = 8'd4;
    b.shm = 4'b0001;
    restart(a);
    f = frame_len(a);
    m = 0;
    for (int k = 0; k < 2 * f; k++) begin
      @(negedge clk);
      if (k < f) begin
        if (obs() !== model(a, k)) m++;
      end else begin
        if (obs() !== model(b, k - f)) m++;
      end
      if (k == f / 2) apply(b);
    end
    chk(m == 0, "R9 change applied only at next frame", m, 0);
    done = 1'b1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule